// File: doc/BRIEF.md
# Per-Pin Input Deglitch Filter with Shared Slow Divider

This block cleans up a bank of general-purpose inputs before they reach edge or level detection. Every raw input first passes through a two-flop synchronizer. Each pin can then either pass its synchronized value straight through, or hold it back until the value has been seen at two filter ticks in a row. A glitch that is not seen at two ticks in a row never reaches the filtered output.

Each pin picks its own tick source. The default source ticks on every clock, so only one-cycle glitches are rejected. The other source is a single slow tick that all pins share. It comes from one programmable counter that fires once every (divider + 1) clocks, which gives a debounce period of 2 × (divider + 1) clocks. Configuration uses a simple write port. Selector 0 writes the mask of pins that have debounce on. Selector 1 writes the mask of pins that use the slow tick. Selector 2 writes the divider. Selector 3 is unused.

Top module: `gpio_deglitch`

## Requirements
- R1: While reset is asserted, every filtered output is 0, the divider is 0 and both enable masks are 0.
- R2: A pin whose debounce-enable bit is 0 shows its raw input on the output two clocks later, and a raw pulse lasting one clock still passes through.
- R3: A pin with debounce on and the slow tick off shows a raw change four clocks after it is applied, rejects a one-clock raw pulse, and passes a two-clock raw pulse.
- R4: After the divider is written with D ≥ 1 in the same cycle that the raw input of a slow-tick pin changes, the output is unchanged for 2D+2 clocks and shows the new value after 2D+3 clocks.
- R5: A slow-tick pin rejects a raw pulse that falls between two of its ticks, and its filtered value changes only on a cycle where its tick fires.
- R6: Every write to the divider selector (code 2) restarts the shared tick counter from zero, so the timing of R4 holds whatever the counter held before the write.
- R7: Pins are independent: in the same cycles, a slow-tick pin rejects a pulse that a fast-tick pin passes.
- R8: The divider keeps only the low 24 bits of the write data, and the upper bits have no effect on timing.
- R9: Turning on debounce and the slow tick for a pin whose input is steady causes no change on that pin's output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. The fast filter tick runs on this clock. |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Selector: 0 debounce-enable mask, 1 slow-tick mask, 2 divider, 3 unused |
| cfg_wdata | input | 32 | Write data (bit i belongs to pin i; the divider uses bits 23:0) |
| pin_raw | input | 32 | Asynchronous raw inputs |
| pin_filt | output | 32 | Filtered inputs |

## Verification
The bench times slow-mode changes to the exact cycle after a divider write. A design whose counter is not restarted on the write, or whose period is off by one, moves the edge by one or more clocks. Short pulses are placed so that they fall between two slow ticks. In the same cycles a fast-tick pin must pass them, so a design that shares one tick source across all pins, or that samples only once, lets the glitch through on the slow pin or swallows it on the fast pin. The bench also writes a divider with junk in its upper bits and turns on debounce for a pin that is already high. These catch a design that keeps the wide value, and a filter state that sat stale while debounce was off and then glitches on enable.

// File: rtl/gpio_deglitch.sv
module gpio_deglitch #(
  parameter int NPIN = 32,
  parameter int DIVW = 24,
  parameter int SYNC = 2
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      cfg_we,
  input  logic [1:0]                                cfg_addr,
  input  logic [((NPIN > DIVW) ? NPIN : DIVW)-1:0]  cfg_wdata,
  input  logic [NPIN-1:0]                           pin_raw,
  output logic [NPIN-1:0]                           pin_filt
);

  localparam logic [1:0] SEL_DBEN = 2'd0;
  localparam logic [1:0] SEL_SLOW = 2'd1;
  localparam logic [1:0] SEL_DIV  = 2'd2;

  logic [NPIN-1:0] sync_q [SYNC];
  logic [NPIN-1:0] sync_s;
  logic [NPIN-1:0] db_en, slow_en;
  logic [DIVW-1:0] div_q, div_cnt;
  logic            div_wr, slow_tick;
  logic [NPIN-1:0] pin_tick, hist_q, filt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < SYNC; k++) sync_q[k] <= '0;
    end else begin
      sync_q[0] <= pin_raw;
      for (int k = 1; k < SYNC; k++) sync_q[k] <= sync_q[k-1];
    end
  end
  assign sync_s = sync_q[SYNC-1];

  assign div_wr = cfg_we && (cfg_addr == SEL_DIV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      db_en   <= '0;
      slow_en <= '0;
      div_q   <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        SEL_DBEN: db_en   <= cfg_wdata[NPIN-1:0];
        SEL_SLOW: slow_en <= cfg_wdata[NPIN-1:0];
        SEL_DIV:  div_q   <= cfg_wdata[DIVW-1:0];
        default:  ;
      endcase
    end
  end

  assign slow_tick = (div_cnt == div_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 div_cnt <= '0;
    else if (div_wr || slow_tick) div_cnt <= '0;
    else                        div_cnt <= div_cnt + 1'b1;
  end

  assign pin_tick = ~slow_en | {NPIN{slow_tick}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      filt_q <= '0;
    end else begin
      for (int i = 0; i < NPIN; i++) begin
        if (!db_en[i]) begin
          hist_q[i] <= sync_s[i];
          filt_q[i] <= sync_s[i];
        end else if (pin_tick[i]) begin
          hist_q[i] <= sync_s[i];
          if (hist_q[i] == sync_s[i]) filt_q[i] <= sync_s[i];
        end
      end
    end
  end

  assign pin_filt = (db_en & filt_q) | (~db_en & sync_s);

endmodule

// File: rtl/gpio_deglitch_chk.sv
module gpio_deglitch_chk #(
  parameter int NPIN = 32,
  parameter int DIVW = 24
) (
  input logic            clk,
  input logic            rst_n,
  input logic            div_wr,
  input logic [DIVW-1:0] div_cnt,
  input logic [DIVW-1:0] div_q,
  input logic [NPIN-1:0] db_en,
  input logic [NPIN-1:0] pin_tick,
  input logic [NPIN-1:0] filt_q,
  input logic [NPIN-1:0] pin_filt
);

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_state_R1: assert (pin_filt == '0 && div_q == '0 && db_en == '0);
    end
  end

  assert_cnt_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    div_cnt <= div_q);

  assert_div_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    div_wr |=> (div_cnt == '0));

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    assert_change_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (db_en[i] && $past(db_en[i]) && !$stable(filt_q[i])) |-> $past(pin_tick[i]));
  end

endmodule

bind gpio_deglitch gpio_deglitch_chk #(.NPIN(NPIN), .DIVW(DIVW)) u_chk (
  .clk(clk), .rst_n(rst_n), .div_wr(div_wr), .div_cnt(div_cnt), .div_q(div_q),
  .db_en(db_en), .pin_tick(pin_tick), .filt_q(filt_q), .pin_filt(pin_filt)
);

// File: tb/gpio_deglitch_test.sv
`timescale 1ns/1ps
module gpio_deglitch_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] raw = '0;
  logic [31:0] pin_filt;
  int checks = 0;
  int fails = 0;

  gpio_deglitch uut (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
                     .cfg_wdata(cfg_wdata), .pin_raw(raw), .pin_filt(pin_filt));

  always #2.5 clk = ~clk;

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    step(1);
    cfg_we = 1'b0;
  endtask

  task automatic t_reset;
    raw = '1;
    step(5);
    chk(pin_filt == '0, "R1 outputs in reset", pin_filt, 32'h0);
    raw = '0;
    rst_n = 1'b1;
    step(4);
    chk(pin_filt == '0, "R1 outputs after release", pin_filt, 32'h0);
  endtask

  task automatic t_bypass;
    raw[5] = 1'b1;
    step(1);
    chk(pin_filt[5] == 1'b0, "R2 bypass one clock", pin_filt[5], 1'b0);
    step(1);
    chk(pin_filt[5] == 1'b1, "R2 bypass two clocks", pin_filt[5], 1'b1);
    raw[5] = 1'b0;
    step(3);
    raw[5] = 1'b1;
    step(1);
    raw[5] = 1'b0;
    step(1);
    chk(pin_filt[5] == 1'b1, "R2 one-clock pulse passes", pin_filt[5], 1'b1);
    step(1);
    chk(pin_filt[5] == 1'b0, "R2 pulse ends", pin_filt[5], 1'b0);
  endtask

  task automatic t_fast;
    bit seen;
    wr(2'd1, 32'h0);
    wr(2'd0, 32'h4);
    raw[2] = 1'b1;
    step(3);
    chk(pin_filt[2] == 1'b0, "R3 held before four clocks", pin_filt[2], 1'b0);
    step(1);
    chk(pin_filt[2] == 1'b1, "R3 change at four clocks", pin_filt[2], 1'b1);
    raw[2] = 1'b0;
    step(4);
    chk(pin_filt[2] == 1'b0, "R3 falling at four clocks", pin_filt[2], 1'b0);
    raw[2] = 1'b1;
    step(1);
    raw[2] = 1'b0;
    seen = 0;
    for (int k = 0; k < 6; k++) begin
      step(1);
      if (pin_filt[2]) seen = 1;
    end
    chk(!seen, "R3 one-clock pulse rejected", seen, 1'b0);
    raw[2] = 1'b1;
    step(2);
    raw[2] = 1'b0;
    seen = 0;
    for (int k = 0; k < 6; k++) begin
      step(1);
      if (pin_filt[2]) seen = 1;
    end
    chk(seen, "R3 two-clock pulse passes", seen, 1'b1);
    chk(pin_filt[2] == 1'b0, "R3 pulse settles low", pin_filt[2], 1'b0);
  endtask

  task automatic slow_edge(input logic [31:0] divw, input int d, input logic val, input string req);
    cfg_we = 1'b1; cfg_addr = 2'd2; cfg_wdata = divw; raw[0] = val;
    step(1);
    cfg_we = 1'b0;
    for (int k = 2; k <= 2*d + 3; k++) begin
      step(1);
      if (k == 2*d + 2) chk(pin_filt[0] == ~val, {req, " held at 2D+2"}, pin_filt[0], ~val);
      if (k == 2*d + 3) chk(pin_filt[0] == val, {req, " changed at 2D+3"}, pin_filt[0], val);
    end
  endtask

  task automatic t_slow_timing;
    wr(2'd1, 32'h1);
    wr(2'd0, 32'h1);
    step(4);
    slow_edge(32'd3, 3, 1'b1, "R4 rising");
    step(2);
    slow_edge(32'd3, 3, 1'b0, "R6 restart falling");
    step(5);
    slow_edge(32'd5, 5, 1'b1, "R6 restart new divider");
    step(3);
    slow_edge(32'hFF000002, 2, 1'b0, "R8 upper bits ignored");
  endtask

  task automatic t_glitch;
    bit seen0, seen1;
    wr(2'd1, 32'h1);
    wr(2'd0, 32'h3);
    raw[1:0] = 2'b00;
    step(10);
    cfg_we = 1'b1; cfg_addr = 2'd2; cfg_wdata = 32'd3;
    step(1);
    cfg_we = 1'b0;
    step(2);
    raw[1:0] = 2'b11;
    step(2);
    raw[1:0] = 2'b00;
    seen0 = 0; seen1 = 0;
    for (int k = 0; k < 12; k++) begin
      step(1);
      if (pin_filt[0]) seen0 = 1;
      if (pin_filt[1]) seen1 = 1;
    end
    chk(!seen0, "R5 slow pin rejects pulse between ticks", seen0, 1'b0);
    chk(seen1, "R7 fast pin passes same pulse", seen1, 1'b1);
  endtask

  task automatic t_enable_quiet;
    bit dropped;
    raw[7] = 1'b1;
    wr(2'd0, 32'h0);
    step(3);
    chk(pin_filt[7] == 1'b1, "R9 bypass high before enable", pin_filt[7], 1'b1);
    wr(2'd1, 32'h80);
    wr(2'd0, 32'h80);
    dropped = 0;
    for (int k = 0; k < 12; k++) begin
      step(1);
      if (!pin_filt[7]) dropped = 1;
    end
    chk(!dropped, "R9 enabling causes no change", dropped, 1'b0);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog all requirements actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    step(1);
    t_reset;
    t_bypass;
    t_fast;
    t_slow_timing;
    t_glitch;
    t_enable_quiet;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule